// File: doc/BRIEF.md
# Interconnect Transaction Timeout Monitor

This block watches the bus transactions of several initiators and flags the ones that take too long. Each initiator has two elapsed-time counters. One measures the time from a request until the target accepts it. The other measures the time from a request until the response comes back. On every cycle each counter is compared with a programmable limit. A counter that reaches its limit sets a sticky bit for that initiator. The acceptance overruns and the response overruns are kept in two separate status words.

A single error line pulses once when the first status bit becomes set. It stays quiet until software has cleared every bit. A small register port lets software do three things: program both limits, read and acknowledge the status, and stop all running counters. Counters are stopped by a privileged write of a key code to a control field. That field then falls back to its idle code without any further write. The initiator handshakes are modelled as one-cycle request, accept and response pulses.

Top module: `xact_timeout_mon`

## Requirements
- R1: After reset the limit word (address 0) reads 0x0400_0400, both status words (addresses 1 and 2) read 0, and the control word (address 3) reads 0x5 in bits [3:0].
- R2: A request pulse on initiator i restarts its acceptance counter at 0. The counter advances once per cycle. If it is still running when it reaches the acceptance limit, bit i of status word 0 (address 1) is set. An accept pulse given at the edge where the count is one below the limit leaves the bit clear.
- R3: The response counter of initiator i works in the same way against the response limit. It is stopped by a response pulse, and an overrun sets bit i of status word 1 (address 2).
- R4: In the limit word, bits [15:0] hold the acceptance limit and bits [31:16] hold the response limit. Both fields are writable and read back as written.
- R5: Status bits are sticky. A bit clears only when software writes 1 to that bit position of its status word. Writing 0 leaves the bit unchanged.
- R6: The error output is a one-cycle pulse. It fires when the status words go from all-zero to non-zero. While any bit stays set, further overruns do not make it fire again. Once all bits are clear, a new overrun fires it again.
- R7: A privileged write of 0xA to bits [3:0] of the control word stops every counter and resets it to 0. No overrun follows from transactions that were running at that point. The field then reads 0x5 again.
- R8: A write of 0xA to the control word without privilege is ignored. Running counters keep counting and still overrun.
- R9: A privileged control write of any value other than 0xA has no effect on the counters. The field still reads 0x5.
- R10: Counters saturate at their maximum value instead of wrapping. A transaction that is never answered therefore keeps its overrun condition indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | N_INIT | Request pulse, one bit per initiator |
| acc | input | N_INIT | Acceptance pulse, one bit per initiator |
| rsp | input | N_INIT | Response pulse, one bit per initiator |
| reg_wr | input | 1 | Register write strobe |
| reg_priv | input | 1 | Write is privileged |
| reg_addr | input | 2 | Register address (0 limits, 1 status 0, 2 status 1, 3 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| err_event | output | 1 | One-cycle error pulse |

## Verification
A wrong counter or comparison shows up as a status bit that sets one cycle early or late. The bench catches this by placing accept pulses exactly at the limit and one cycle below it. A lost or spurious key decode shows up a dozen cycles later: a status bit appears for a stopped transaction, or stays clear for a live one, and the control word reads back a value other than 0x5. A counter that wraps instead of saturating is exposed after the maximum count is reached. At that point a status acknowledge stays cleared instead of being set again at once. A faulty error edge detector shows up as a wrong running count of pulses, which the bench checks after each status change.

// File: rtl/itm_pkg.sv
`timescale 1ns/1ps
package itm_pkg;
  typedef enum logic [1:0] {
    ADDR_LIMIT = 2'd0,
    ADDR_STAT0 = 2'd1,
    ADDR_STAT1 = 2'd2,
    ADDR_CTRL  = 2'd3
  } itm_addr_e;

  localparam logic [3:0] KEY_CLEAR = 4'hA;
  localparam logic [3:0] KEY_IDLE  = 4'h5;
  localparam int         REG_W     = 32;
endpackage

// File: rtl/itm_lat_counter.sv
`timescale 1ns/1ps
module itm_lat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (stop) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_q && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign overrun = run_q && (cnt_q >= limit);

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX && !start && !stop && !clr) |=> (run_q && cnt_q == CNT_MAX)); // R10
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> (run_q && cnt_q == '0)); // R2
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !overrun); // R7
endmodule

// File: rtl/itm_status.sv
`timescale 1ns/1ps
module itm_status #(
  parameter int N_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] set0,
  input  logic [N_INIT-1:0] set1,
  input  logic [N_INIT-1:0] w1c0,
  input  logic [N_INIT-1:0] w1c1,
  output logic [N_INIT-1:0] stat0,
  output logic [N_INIT-1:0] stat1,
  output logic              err_event
);
  logic [N_INIT-1:0] stat0_q, stat0_d, stat1_q, stat1_d;
  logic              any_q, any_now;

  always_comb begin
    stat0_d = (stat0_q & ~w1c0) | set0;
    stat1_d = (stat1_q & ~w1c1) | set1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat0_q <= '0;
      stat1_q <= '0;
      any_q   <= 1'b0;
    end else begin
      stat0_q <= stat0_d;
      stat1_q <= stat1_d;
      any_q   <= any_now;
    end
  end

  assign any_now   = (|stat0_q) | (|stat1_q);
  assign err_event = any_now & ~any_q;
  assign stat0     = stat0_q;
  assign stat1     = stat1_q;

  AST_STICKY0: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat0_q) & ~$past(w1c0) & ~stat0_q) == '0)); // R5
  AST_STICKY1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat1_q) & ~$past(w1c1) & ~stat1_q) == '0)); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> !err_event); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (any_now && ((set0 | set1) != '0)) |=> !err_event); // R6
endmodule

// File: rtl/itm_regs.sv
`timescale 1ns/1ps
module itm_regs
  import itm_pkg::*;
#(
  parameter int N_INIT    = 4,
  parameter int CNT_W     = 16,
  parameter int LIMIT_RST = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              priv,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N_INIT-1:0] stat0,
  input  logic [N_INIT-1:0] stat1,
  output logic [CNT_W-1:0]  lim_acc,
  output logic [CNT_W-1:0]  lim_rsp,
  output logic [N_INIT-1:0] w1c0,
  output logic [N_INIT-1:0] w1c1,
  output logic              cnt_clr,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [CNT_W-1:0] LIM_INIT = CNT_W'(LIMIT_RST);
  localparam int               HI_LSB   = REG_W / 2;

  itm_addr_e  sel;
  logic [CNT_W-1:0] lim_acc_q, lim_rsp_q;
  logic             lim_en;
  logic [3:0]       key_q, key_d;
  logic             key_en;

  assign sel    = itm_addr_e'(addr);
  assign lim_en = wr && (sel == ADDR_LIMIT);

  always_comb begin
    key_d  = key_q;
    key_en = 1'b0;
    if (key_q == KEY_CLEAR) begin
      key_d  = KEY_IDLE;
      key_en = 1'b1;
    end else if (wr && priv && (sel == ADDR_CTRL) && (wdata[3:0] == KEY_CLEAR)) begin
      key_d  = KEY_CLEAR;
      key_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_acc_q <= LIM_INIT;
      lim_rsp_q <= LIM_INIT;
    end else if (lim_en) begin
      lim_acc_q <= wdata[CNT_W-1:0];
      lim_rsp_q <= wdata[HI_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= KEY_IDLE;
    else if (key_en) key_q <= key_d;
  end

  assign cnt_clr = (key_q == KEY_CLEAR);
  assign lim_acc = lim_acc_q;
  assign lim_rsp = lim_rsp_q;
  assign w1c0    = (wr && sel == ADDR_STAT0) ? wdata[N_INIT-1:0] : '0;
  assign w1c1    = (wr && sel == ADDR_STAT1) ? wdata[N_INIT-1:0] : '0;

  always_comb begin
    rdata = '0;
    unique case (sel)
      ADDR_LIMIT: begin
        rdata[CNT_W-1:0]         = lim_acc_q;
        rdata[HI_LSB +: CNT_W]   = lim_rsp_q;
      end
      ADDR_STAT0: rdata[N_INIT-1:0] = stat0;
      ADDR_STAT1: rdata[N_INIT-1:0] = stat1;
      ADDR_CTRL:  rdata[3:0]        = KEY_IDLE;
    endcase
  end

  AST_KEY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q == KEY_CLEAR) |=> (key_q == KEY_IDLE)); // R7
  AST_KEY_NONPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !priv && key_q != KEY_CLEAR) |=> (key_q == KEY_IDLE)); // R8
  AST_KEY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q == KEY_IDLE) || (key_q == KEY_CLEAR)); // R9
endmodule

// File: rtl/xact_timeout_mon.sv
`timescale 1ns/1ps
module xact_timeout_mon
  import itm_pkg::*;
#(
  parameter int N_INIT    = 4,
  parameter int CNT_W     = 16,
  parameter int LIMIT_RST = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] req,
  input  logic [N_INIT-1:0] acc,
  input  logic [N_INIT-1:0] rsp,
  input  logic              reg_wr,
  input  logic              reg_priv,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err_event
);
  logic              rst_s1, rst_n_s;
  logic [CNT_W-1:0]  lim_acc, lim_rsp;
  logic [N_INIT-1:0] ovr_acc, ovr_rsp, w1c0, w1c1, stat0, stat1;
  logic              cnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  for (genvar i = 0; i < N_INIT; i++) begin : g_init
    itm_lat_counter #(.CNT_W(CNT_W)) u_acc_cnt (
      .clk(clk), .rst_n(rst_n_s), .start(req[i]), .stop(acc[i]),
      .clr(cnt_clr), .limit(lim_acc), .overrun(ovr_acc[i])
    );
    itm_lat_counter #(.CNT_W(CNT_W)) u_rsp_cnt (
      .clk(clk), .rst_n(rst_n_s), .start(req[i]), .stop(rsp[i]),
      .clr(cnt_clr), .limit(lim_rsp), .overrun(ovr_rsp[i])
    );
  end

  itm_status #(.N_INIT(N_INIT)) u_status (
    .clk(clk), .rst_n(rst_n_s), .set0(ovr_acc), .set1(ovr_rsp),
    .w1c0(w1c0), .w1c1(w1c1), .stat0(stat0), .stat1(stat1),
    .err_event(err_event)
  );

  itm_regs #(.N_INIT(N_INIT), .CNT_W(CNT_W), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .priv(reg_priv),
    .addr(reg_addr), .wdata(reg_wdata), .stat0(stat0), .stat1(stat1),
    .lim_acc(lim_acc), .lim_rsp(lim_rsp), .w1c0(w1c0), .w1c1(w1c1),
    .cnt_clr(cnt_clr), .rdata(reg_rdata)
  );

  AST_OVR_SETS_STAT0: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovr_acc != '0) |=> ((stat0 & $past(ovr_acc)) == $past(ovr_acc))); // R2
  AST_OVR_SETS_STAT1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovr_rsp != '0) |=> ((stat1 & $past(ovr_rsp)) == $past(ovr_rsp))); // R3
endmodule

// File: tb/xact_timeout_mon_bench.sv
`timescale 1ns/1ps
module xact_timeout_mon_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, acc = '0, rsp = '0;
  logic          reg_wr = 1'b0, reg_priv = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          err_event;

  typedef struct {
    string       tag;
    bit          is_err;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_run = 0, n_fail = 0, err_seen = 0;
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  xact_timeout_mon u_xact_timeout_mon (
    .clk(clk), .rst_n(rst_n), .req(req), .acc(acc), .rsp(rsp),
    .reg_wr(reg_wr), .reg_priv(reg_priv), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_event(err_event)
  );

  // Monitor: counts error pulses and scores queued expectations
  always @(negedge clk) begin
    if (rst_n && err_event) err_seen++;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_err ? 32'(err_seen) : reg_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(logic [1:0] a, logic [31:0] e, string tag);
    item_t it;
    reg_addr  = a;
    it.tag    = tag;
    it.is_err = 1'b0;
    it.exp    = e;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_err(int e, string tag);
    item_t it;
    it.tag    = tag;
    it.is_err = 1'b1;
    it.exp    = 32'(e);
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d, bit p);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_priv = p;
    tick(1);
    reg_wr = 1'b0; reg_priv = 1'b0;
  endtask

  // request pulse sampled at edge e0; returns just after e0
  task automatic pulse_req(int i);
    req[i] = 1'b1;
    tick(1);
    req[i] = 1'b0;
  endtask

  // after pulse_req, put acc/rsp on edge e0+k
  task automatic finish_at(int i, int k, bit do_acc, bit do_rsp);
    if (k > 1) tick(k - 1);
    acc[i] = do_acc; rsp[i] = do_rsp;
    tick(1);
    acc[i] = 1'b0; rsp[i] = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset values
    expect_rd(2'd0, 32'h0400_0400, "R1");
    expect_rd(2'd1, 32'h0, "R1");
    expect_rd(2'd2, 32'h0, "R1");
    expect_rd(2'd3, 32'h5, "R1");

    // R4 limit fields
    tick(1);
    wr_reg(2'd0, {16'd8, 16'd5}, 1'b0);
    expect_rd(2'd0, 32'h0008_0005, "R4");

    // R2 accept one below the limit: no overrun
    tick(1);
    pulse_req(0);
    finish_at(0, 5, 1'b1, 1'b1);
    tick(3);
    expect_rd(2'd1, 32'h0, "R2");
    expect_rd(2'd2, 32'h0, "R3");
    expect_err(0, "R6");

    // R2 accept at the limit: overrun on initiator 1
    pulse_req(1);
    finish_at(1, 6, 1'b1, 1'b1);
    tick(3);
    expect_rd(2'd1, 32'h2, "R2");
    expect_rd(2'd2, 32'h0, "R3");
    expect_err(1, "R6");

    // R3 response overrun on initiator 2; no second pulse
    pulse_req(2);
    finish_at(2, 2, 1'b1, 1'b0);
    finish_at(2, 12, 1'b0, 1'b1);
    tick(2);
    expect_rd(2'd2, 32'h4, "R3");
    expect_err(1, "R6");

    // R5 sticky / write-one-to-clear
    wr_reg(2'd1, 32'h0, 1'b1);
    expect_rd(2'd1, 32'h2, "R5");
    wr_reg(2'd1, 32'h2, 1'b0);
    expect_rd(2'd1, 32'h0, "R5");
    expect_rd(2'd2, 32'h4, "R5");
    wr_reg(2'd2, 32'h4, 1'b0);
    expect_rd(2'd2, 32'h0, "R5");

    // R6 fires again after all clear
    pulse_req(3);
    finish_at(3, 7, 1'b1, 1'b1);
    tick(2);
    expect_rd(2'd1, 32'h8, "R6");
    expect_err(2, "R6");
    wr_reg(2'd1, 32'h8, 1'b0);

    // R7 privileged key stops counters
    tick(2);
    pulse_req(0);
    tick(1);
    wr_reg(2'd3, 32'hA, 1'b1);
    tick(14);
    expect_rd(2'd1, 32'h0, "R7");
    expect_rd(2'd2, 32'h0, "R7");
    expect_rd(2'd3, 32'h5, "R7");
    expect_err(2, "R7");

    // R8 non-privileged key ignored
    pulse_req(0);
    tick(1);
    wr_reg(2'd3, 32'hA, 1'b0);
    expect_rd(2'd3, 32'h5, "R8");
    tick(12);
    expect_rd(2'd1, 32'h1, "R8");
    expect_rd(2'd2, 32'h1, "R8");
    expect_err(3, "R8");
    acc[0] = 1'b1; rsp[0] = 1'b1; tick(1); acc[0] = 1'b0; rsp[0] = 1'b0;
    wr_reg(2'd1, 32'h1, 1'b0);
    wr_reg(2'd2, 32'h1, 1'b0);
    expect_rd(2'd1, 32'h0, "R8");

    // R9 other key value has no effect
    tick(2);
    pulse_req(1);
    tick(1);
    wr_reg(2'd3, 32'h3, 1'b1);
    expect_rd(2'd3, 32'h5, "R9");
    tick(12);
    expect_rd(2'd1, 32'h2, "R9");
    expect_rd(2'd2, 32'h2, "R9");
    expect_err(4, "R9");
    acc[1] = 1'b1; rsp[1] = 1'b1; tick(1); acc[1] = 1'b0; rsp[1] = 1'b0;
    wr_reg(2'd1, 32'h2, 1'b0);
    wr_reg(2'd2, 32'h2, 1'b0);

    // R10 saturation at the maximum count
    tick(2);
    wr_reg(2'd0, 32'hFFFF_FFFF, 1'b0);
    pulse_req(0);
    tick(65540);
    expect_rd(2'd1, 32'h1, "R10");
    expect_err(5, "R10");
    wr_reg(2'd1, 32'h1, 1'b0);
    tick(2);
    expect_rd(2'd1, 32'h1, "R10");

    tick(2);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule